// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This purely combinational datapath slice serves the single-operand bit instructions of an 8-bit processor core. It takes one operand byte, a separate carry input, a 4-bit operation code, a 3-bit bit index and the current flag byte. In the same evaluation it returns a result byte and an updated flag byte. The surrounding core decides where the result goes and whether to write the flags back.

Three families share one shifter. The first is the eight extended rotate/shift operations, which rewrite every flag from the result. The second is the four fast accumulator rotates, which give the same result bytes as their extended counterparts but leave sign, zero and parity untouched. The third is a bit test that reports on one selected bit of the operand and passes the operand through unchanged.

Top module: `rsb_unit`

Flag byte layout, used by every requirement below: bit 7 S (sign), bit 6 Z (zero), bit 5 F5, bit 4 H (half-carry), bit 3 F3, bit 2 PV (parity/overflow), bit 1 N (subtract), bit 0 C (carry).

## Requirements
- R1: Rotates, operation codes 0 to 3. Code 0 rotates left with bit 7 copied into bit 0. Code 1 rotates right with bit 0 copied into bit 7. Code 2 rotates left with carry_i entering bit 0. Code 3 rotates right with carry_i entering bit 7.
- R2: Shifts, operation codes 4 to 7. Code 4 shifts left inserting 0. Code 5 shifts right and keeps bit 7. Code 6 shifts left inserting 1. Code 7 shifts right inserting 0.
- R3: Fast rotates, codes 8, 9, 10 and 11, produce the same results as codes 0, 1, 2 and 3. Flag bit 0 (C) takes the bit shifted out, and bits 4 (H) and 1 (N) are cleared. Bits 3 (F3) and 5 (F5) copy result bits 3 and 5. Bits 7 (S), 6 (Z) and 2 (PV) keep their flags_i values.
- R4: For codes 0 to 7, flag bit 0 (C) takes the bit shifted out, and bits 4 (H) and 1 (N) are cleared. Bit 7 (S) equals result bit 7, and bit 6 (Z) is set when the result is zero. Bits 5 and 3 copy the matching result bits. Bit 2 (PV) is set when the result has an even number of ones.
- R5: Bit test, code 12, examines operand bit bit_sel_i. Flag bits 6 (Z) and 2 (PV) are both set to the inverse of that bit. Bit 4 (H) is set, bit 1 (N) is cleared, and bit 0 (C) keeps flags_i bit 0.
- R6: In the bit test, flag bit 7 (S) is set only when the tested bit is 1 and the index is 7. Bit 3 (F3) is set only when the tested bit is 1 and the index is 3. Bit 5 (F5) is set only when the tested bit is 1 and the index is 5. A tested bit of 0 clears all three.
- R7: The bit test returns the operand unchanged on result_o.
- R8: Codes 13, 14 and 15 are spare. They return the operand on result_o and flags_i on flags_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 8 | Operand byte |
| carry_i | input | 1 | Carry fed into the through-carry rotates |
| op_i | input | 4 | Operation code |
| bit_sel_i | input | 3 | Bit index for the bit test |
| flags_i | input | 8 | Current flag byte |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | New flag byte |

## Verification
In one evaluation the through-carry rotates consume carry_i and also produce a new carry. A fast rotate also merges freshly computed bits with preserved ones in the same flag byte. The sweep provokes both cases by setting carry_i opposite to the outgoing bit and by giving flags_i S, Z and PV values that disagree with what the result would imply. Each output byte is judged against a model that builds the expected flag byte from the requirements, so a mixed-up source for any single flag bit shows up.

// File: rtl/rsb_unit.sv
module rsb_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0]         operand_i,
  input  logic                 carry_i,
  input  logic [3:0]           op_i,
  input  logic [$clog2(W)-1:0] bit_sel_i,
  input  logic [7:0]           flags_i,
  output logic [W-1:0]         result_o,
  output logic [7:0]           flags_o
);
  localparam logic [3:0] OP_BIT = 4'd12;

  logic [2:0]   kind;
  logic [W-1:0] sh;
  logic         out_bit;
  logic         tbit;
  logic         is_ext, is_fast, is_bit;

  assign is_ext  = (op_i[3] == 1'b0);
  assign is_fast = (op_i[3:2] == 2'b10);
  assign is_bit  = (op_i == OP_BIT);
  assign kind    = is_ext ? op_i[2:0] : {1'b0, op_i[1:0]};
  assign tbit    = operand_i[bit_sel_i];

  always_comb begin
    out_bit = kind[0] ? operand_i[0] : operand_i[W-1];
    case (kind)
      3'd0:    sh = {operand_i[W-2:0], operand_i[W-1]};
      3'd1:    sh = {operand_i[0], operand_i[W-1:1]};
      3'd2:    sh = {operand_i[W-2:0], carry_i};
      3'd3:    sh = {carry_i, operand_i[W-1:1]};
      3'd4:    sh = {operand_i[W-2:0], 1'b0};
      3'd5:    sh = {operand_i[W-1], operand_i[W-1:1]};
      3'd6:    sh = {operand_i[W-2:0], 1'b1};
      default: sh = {1'b0, operand_i[W-1:1]};
    endcase
  end

  always_comb begin
    result_o = operand_i;
    flags_o  = flags_i;
    if (is_ext) begin
      result_o = sh;
      flags_o  = {sh[W-1], (sh == '0), sh[5], 1'b0, sh[3], ~^sh, 1'b0, out_bit};
    end else if (is_fast) begin
      result_o = sh;
      flags_o  = {flags_i[7], flags_i[6], sh[5], 1'b0, sh[3], flags_i[2], 1'b0, out_bit};
    end else if (is_bit) begin
      flags_o = {tbit & (bit_sel_i == 7), ~tbit, tbit & (bit_sel_i == 5), 1'b1,
                 tbit & (bit_sel_i == 3), ~tbit, 1'b0, flags_i[0]};
    end
  end
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk (
  input logic [7:0] operand_i,
  input logic [3:0] op_i,
  input logic [7:0] flags_i,
  input logic [7:0] result_o,
  input logic [7:0] flags_o
);
  always_comb begin
    if (!$isunknown({operand_i, op_i, flags_i})) begin
      if (op_i == 4'd12) begin
        p_bit_passthru_r7: assert (result_o == operand_i) else $error("R7 bit test altered operand");
        p_bit_hnc_r5: assert (flags_o[4] && !flags_o[1] && flags_o[0] == flags_i[0]) else $error("R5 H/N/C");
        p_bit_z_pv_r5: assert (flags_o[6] == flags_o[2]) else $error("R5 Z and PV differ");
        p_bit_szero_r6: assert (!(flags_o[6] && (flags_o[7] || flags_o[5] || flags_o[3]))) else $error("R6 S/F5/F3 with clear bit");
      end
      if (op_i[3:2] == 2'b10) begin
        p_fast_keep_r3: assert (flags_o[7] == flags_i[7] && flags_o[6] == flags_i[6] && flags_o[2] == flags_i[2])
          else $error("R3 preserved flags changed");
      end
      if (!op_i[3]) begin
        p_ext_parity_r4: assert (flags_o[2] == ~^result_o) else $error("R4 parity");
        p_ext_hn_r4: assert (!flags_o[4] && !flags_o[1]) else $error("R4 H/N");
      end
      if (!op_i[3] && !op_i[0]) begin
        p_left_carry_r1: assert (flags_o[0] == operand_i[7]) else $error("R1 left carry");
      end
      if (op_i >= 4'd13) begin
        p_spare_r8: assert (result_o == operand_i && flags_o == flags_i) else $error("R8 spare code");
      end
    end
  end
endmodule

bind rsb_unit rsb_unit_chk i_chk (
  .operand_i(operand_i),
  .op_i(op_i),
  .flags_i(flags_i),
  .result_o(result_o),
  .flags_o(flags_o)
);

// File: tb/test_rsb_unit.sv
module test_rsb_unit;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic [7:0] operand_i = '0;
  logic       carry_i = 1'b0;
  logic [3:0] op_i = 4'd15;
  logic [2:0] bit_sel_i = '0;
  logic [7:0] flags_i = '0;
  logic [7:0] result_o, flags_o;

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] r;
    logic [7:0] f;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit driving_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsb_unit i_rsb_unit (
    .operand_i(operand_i), .carry_i(carry_i), .op_i(op_i),
    .bit_sel_i(bit_sel_i), .flags_i(flags_i),
    .result_o(result_o), .flags_o(flags_o)
  );

  function automatic string tag_res(input logic [3:0] op);
    if (op <= 3) return "R1";
    if (op <= 7) return "R2";
    if (op <= 11) return "R3";
    if (op == 12) return "R7";
    return "R8";
  endfunction

  function automatic string tag_flg(input logic [3:0] op);
    if (op <= 7) return "R4";
    if (op <= 11) return "R3";
    if (op == 12) return "R5/R6";
    return "R8";
  endfunction

  function automatic exp_t model(input logic [3:0] op, input logic [7:0] v,
                                 input logic c, input logic [2:0] b, input logic [7:0] fl);
    exp_t e;
    int k;
    logic co, fill, t;
    e.op = op; e.r = v; e.f = fl;
    if (op <= 11) begin
      k = (op <= 7) ? int'(op) : int'(op) - 8;
      if (k % 2 == 0) begin
        co = v[7];
        fill = (k == 0) ? v[7] : (k == 2) ? c : (k == 4) ? 1'b0 : 1'b1;
        e.r = 8'((16'(v) * 2) + 16'(fill));
      end else begin
        co = v[0];
        fill = (k == 1) ? v[0] : (k == 3) ? c : (k == 5) ? v[7] : 1'b0;
        e.r = 8'(v / 2) + (fill ? 8'h80 : 8'h00);
      end
      if (op <= 7)
        e.f = {e.r[7], e.r == 8'd0, e.r[5], 1'b0, e.r[3], ($countones(e.r) % 2) == 0, 1'b0, co};
      else
        e.f = {fl[7], fl[6], e.r[5], 1'b0, e.r[3], fl[2], 1'b0, co};
    end else if (op == 12) begin
      t = v[b];
      e.f = {t && b == 3'd7, !t, t && b == 3'd5, 1'b1, t && b == 3'd3, !t, 1'b0, fl[0]};
    end
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [7:0] v, input logic c,
                       input logic [2:0] b, input logic [7:0] fl);
    @(posedge clk);
    op_i = op; operand_i = v; carry_i = c; bit_sel_i = b; flags_i = fl;
    q.push_back(model(op, v, c, b, fl));
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (result_o !== e.r) begin
        errors++;
        $display("FAIL %s op=%0d result actual=%02h expected=%02h", tag_res(e.op), e.op, result_o, e.r);
      end
      checks++;
      if (flags_o !== e.f) begin
        errors++;
        $display("FAIL %s op=%0d flags actual=%08b expected=%08b", tag_flg(e.op), e.op, flags_o, e.f);
      end
    end
  end

  initial begin
    // R1 R2 R4: extended forms; R3: fast forms with conflicting preserved flags
    for (int op = 0; op < 12; op++)
      for (int v = 0; v < 256; v++)
        for (int c = 0; c < 2; c++)
          drive(4'(op), 8'(v), 1'(c), 3'd0, 8'(v) ^ 8'h5A ^ {1'(c), 7'd0} ^ {5'd0, 1'(op), 2'd0});
    // R5 R6 R7: every operand with every bit index, carry flag toggled
    for (int b = 0; b < 8; b++)
      for (int v = 0; v < 256; v++)
        drive(4'd12, 8'(v), 1'(v), 3'(b), ~8'(v) ^ {7'd0, 1'(b)});
    // R8: spare codes
    for (int op = 13; op < 16; op++)
      for (int v = 0; v < 256; v++)
        drive(4'(op), 8'(v), 1'(v >> 1), 3'(v), 8'(v * 3));
    @(posedge clk);
    @(posedge clk);
    driving_done = 1;
  end

  initial begin
    int cyc = 0;
    while (!driving_done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!driving_done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<100000 cycles", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule